// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache Controller

This block is a byte-wide data cache. It sits between a processor load/store port and a memory port that moves whole lines. A request address is split three ways: the high bits are the tag, the middle bits select the set, and the low bits pick a byte inside the line. Each set holds eight ways. Every way keeps a state (invalid, clean or dirty), a stored tag, a saturating age counter and one data line.

A request that hits is answered from the array. On a miss, the controller first looks for a free way; if none is free, it takes the oldest one. A dirty victim is written back to memory as a whole line. The line is then fetched from memory. A store merges its byte into the line and leaves it dirty, whether the store hit or missed.

The processor holds its request on `cpu_valid` until `cpu_ready` pulses. Memory requests and responses each use their own valid/ready handshake.

Top module: `wbc_cache_ctrl`

## Requirements
- R1: Reset behaviour. After reset every way is invalid with age zero, and `cpu_ready`, `mem_req_valid` and `mem_rsp_ready` are low. The first access to any address is therefore a miss.
- R2: Read hit. A read that hits returns the addressed byte on `cpu_rdata` while `cpu_ready` is high. Byte k of a line sits on bits 8k+7..8k of every line bus. `cpu_ready` rises exactly two rising edges after `cpu_valid` is first sampled, and the hit causes no memory request.
- R3: Write hit. A write that hits stores its byte into the line and marks the line dirty. It answers with `cpu_rdata` equal to the written byte, on the same two-edge timing as a read hit.
- R4: Free-way selection. On a miss with at least one invalid way in the set, the lowest-numbered invalid way is filled and no write-back is issued.
- R5: Ageing and victim choice. Every lookup increments the age of all eight ways in the set, saturating at 2^AGE_BITS-1. The hit way, or the way being filled, then has its age set to zero. When every way is valid, the victim is the way with the largest age after that increment; on a tie, the lowest-numbered way wins.
- R6: Victim write-back. A dirty victim produces exactly one write request (`mem_req_write`=1) before the refill. Its address is {stored tag, set index, zero offset} and its data is the victim's whole line. A clean victim produces no write.
- R7: Refill. Every miss produces exactly one read request at the request address with the offset bits cleared. The response line becomes the way's data and the request tag becomes its tag. `cpu_ready` follows on the edge after the response is taken.
- R8: Write-allocate. A write miss refills the line, merges the byte and leaves the way dirty. A read miss leaves the filled way clean.
- R9: Memory handshake. Request fields are held stable while `mem_req_valid` is high and `mem_req_ready` is low. A write completes when accepted and has no response. A read response is taken only on an edge where `mem_rsp_ready` is high.
- R10: Processor handshake. `cpu_ready` is a single-cycle pulse given only for a pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request pending |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | TAG_BITS+INDEX_BITS+OFFSET_BITS | Byte address |
| cpu_wdata | input | 8 | Store byte |
| cpu_ready | output | 1 | Request complete (one-cycle pulse) |
| cpu_rdata | output | 8 | Load byte, or the stored byte on a write |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = line write-back, 0 = line read |
| mem_req_addr | output | TAG_BITS+INDEX_BITS+OFFSET_BITS | Line-aligned address |
| mem_req_wdata | output | 8*2^OFFSET_BITS | Write-back line |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_ready | output | 1 | Controller waiting for a read response |
| mem_rsp_rdata | input | 8*2^OFFSET_BITS | Refill line |

## Verification
A hit must show `cpu_ready` at the second falling edge after the request is applied, and never at the first. The bench counts falling edges from the moment it raises `cpu_valid` and compares at exactly that count. A miss has no fixed latency because the bench's memory stalls at random. For a miss, the bench instead requires `cpu_ready` at the falling edge right after the edge on which the refill response was taken. Every memory request is compared, in order, at the falling edge before it is accepted, against a list the reference model predicted; the list must be empty when `cpu_ready` arrives.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

  typedef enum logic [1:0] {
    LN_INVALID = 2'd0,
    LN_CLEAN   = 2'd1,
    LN_DIRTY   = 2'd2
  } line_state_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_EVICT,
    ST_FETCH,
    ST_AWAIT,
    ST_REPLY
  } ctl_state_e;

endpackage

// File: rtl/wbc_tag_match.sv
module wbc_tag_match #(
  parameter int WAYS     = 8,
  parameter int TAG_BITS = 6,
  localparam int WAY_BITS = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]          way_valid,
  input  logic [WAYS*TAG_BITS-1:0] way_tags,
  input  logic [TAG_BITS-1:0]      look_tag,
  output logic [WAYS-1:0]          hit_vec,
  output logic                     hit,
  output logic [WAY_BITS-1:0]      hit_way
);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = way_valid[w] && (way_tags[w*TAG_BITS +: TAG_BITS] == look_tag);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = WAY_BITS'(w);
    end
  end

endmodule

// File: rtl/wbc_victim_pick.sv
module wbc_victim_pick #(
  parameter int WAYS     = 8,
  parameter int AGE_BITS = 4,
  localparam int WAY_BITS = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]          way_valid,
  input  logic [WAYS*AGE_BITS-1:0] way_ages,
  output logic [WAY_BITS-1:0]      pick_way,
  output logic                     pick_free
);

  logic [WAY_BITS-1:0] free_way;
  logic [WAY_BITS-1:0] old_way;
  logic [AGE_BITS-1:0] old_age;

  always_comb begin
    free_way  = '0;
    pick_free = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!way_valid[w] && !pick_free) begin
        free_way  = WAY_BITS'(w);
        pick_free = 1'b1;
      end
    end
  end

  always_comb begin
    old_way = '0;
    old_age = way_ages[0 +: AGE_BITS];
    for (int w = 1; w < WAYS; w++) begin
      if (way_ages[w*AGE_BITS +: AGE_BITS] > old_age) begin
        old_age = way_ages[w*AGE_BITS +: AGE_BITS];
        old_way = WAY_BITS'(w);
      end
    end
  end

  assign pick_way = pick_free ? free_way : old_way;

endmodule

// File: rtl/wbc_age_next.sv
module wbc_age_next #(
  parameter int WAYS     = 8,
  parameter int AGE_BITS = 4
) (
  input  logic [WAYS*AGE_BITS-1:0] age_now,
  input  logic [WAYS-1:0]          clear_vec,
  output logic [WAYS*AGE_BITS-1:0] age_bumped,
  output logic [WAYS*AGE_BITS-1:0] age_next
);

  localparam logic [AGE_BITS-1:0] AGE_TOP = '1;

  for (genvar w = 0; w < WAYS; w++) begin : g_age
    logic [AGE_BITS-1:0] cur;
    assign cur = age_now[w*AGE_BITS +: AGE_BITS];
    assign age_bumped[w*AGE_BITS +: AGE_BITS] = (cur == AGE_TOP) ? cur : cur + 1'b1;
    assign age_next[w*AGE_BITS +: AGE_BITS]   = clear_vec[w] ? '0 : age_bumped[w*AGE_BITS +: AGE_BITS];
  end

endmodule

// File: rtl/wbc_cache_ctrl.sv
module wbc_cache_ctrl
  import wbc_pkg::*;
#(
  parameter int TAG_BITS    = 6,
  parameter int INDEX_BITS  = 2,
  parameter int OFFSET_BITS = 2,
  parameter int WAYS        = 8,
  parameter int AGE_BITS    = 4
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       cpu_valid,
  input  logic                                       cpu_write,
  input  logic [TAG_BITS+INDEX_BITS+OFFSET_BITS-1:0] cpu_addr,
  input  logic [7:0]                                 cpu_wdata,
  output logic                                       cpu_ready,
  output logic [7:0]                                 cpu_rdata,
  output logic                                       mem_req_valid,
  input  logic                                       mem_req_ready,
  output logic                                       mem_req_write,
  output logic [TAG_BITS+INDEX_BITS+OFFSET_BITS-1:0] mem_req_addr,
  output logic [8*(1<<OFFSET_BITS)-1:0]              mem_req_wdata,
  input  logic                                       mem_rsp_valid,
  output logic                                       mem_rsp_ready,
  input  logic [8*(1<<OFFSET_BITS)-1:0]              mem_rsp_rdata
);

  localparam int ADDR_BITS = TAG_BITS + INDEX_BITS + OFFSET_BITS;
  localparam int LINE_BITS = 8 * (1 << OFFSET_BITS);
  localparam int SETS      = 1 << INDEX_BITS;
  localparam int WAY_BITS  = $clog2(WAYS);

  typedef logic [LINE_BITS-1:0] line_t;

  function automatic logic [7:0] pick_byte(input line_t line, input logic [OFFSET_BITS-1:0] off);
    return line[{off, 3'b000} +: 8];
  endfunction

  function automatic line_t merge_byte(input line_t line, input logic [OFFSET_BITS-1:0] off,
                                       input logic [7:0] b);
    line_t r;
    r = line;
    r[{off, 3'b000} +: 8] = b;
    return r;
  endfunction

  function automatic logic [ADDR_BITS-1:0] line_base(input logic [TAG_BITS-1:0] t,
                                                     input logic [INDEX_BITS-1:0] s);
    return {t, s, {OFFSET_BITS{1'b0}}};
  endfunction

  // storage
  line_state_e         st_q   [SETS][WAYS];
  logic [TAG_BITS-1:0] tag_q  [SETS][WAYS];
  logic [AGE_BITS-1:0] age_q  [SETS][WAYS];
  line_t               data_q [SETS][WAYS];

  // latched request
  ctl_state_e          state_q;
  logic                req_write_q;
  logic [ADDR_BITS-1:0] req_addr_q;
  logic [7:0]          req_wdata_q;
  logic [WAY_BITS-1:0] vic_q;
  logic [7:0]          rdata_q;

  logic [INDEX_BITS-1:0]  req_idx;
  logic [TAG_BITS-1:0]    req_tag;
  logic [OFFSET_BITS-1:0] req_off;
  assign req_idx = req_addr_q[OFFSET_BITS +: INDEX_BITS];
  assign req_tag = req_addr_q[ADDR_BITS-1 -: TAG_BITS];
  assign req_off = req_addr_q[OFFSET_BITS-1:0];

  // view of the addressed set
  logic [WAYS-1:0]          set_valid;
  logic [WAYS*TAG_BITS-1:0] set_tags;
  logic [WAYS*AGE_BITS-1:0] set_ages;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      set_valid[w]                        = (st_q[req_idx][w] != LN_INVALID);
      set_tags[w*TAG_BITS +: TAG_BITS]    = tag_q[req_idx][w];
      set_ages[w*AGE_BITS +: AGE_BITS]    = age_q[req_idx][w];
    end
  end

  logic [WAYS-1:0]          hit_vec;
  logic                     hit;
  logic [WAY_BITS-1:0]      hit_way;
  logic [WAYS*AGE_BITS-1:0] age_bumped;
  logic [WAYS*AGE_BITS-1:0] age_nx;
  logic [WAY_BITS-1:0]      vic_way;
  logic                     vic_free;

  wbc_tag_match #(.WAYS(WAYS), .TAG_BITS(TAG_BITS)) u_match (
    .way_valid (set_valid),
    .way_tags  (set_tags),
    .look_tag  (req_tag),
    .hit_vec   (hit_vec),
    .hit       (hit),
    .hit_way   (hit_way)
  );

  wbc_age_next #(.WAYS(WAYS), .AGE_BITS(AGE_BITS)) u_age (
    .age_now    (set_ages),
    .clear_vec  (hit_vec),
    .age_bumped (age_bumped),
    .age_next   (age_nx)
  );

  wbc_victim_pick #(.WAYS(WAYS), .AGE_BITS(AGE_BITS)) u_victim (
    .way_valid (set_valid),
    .way_ages  (age_bumped),
    .pick_way  (vic_way),
    .pick_free (vic_free)
  );

  // named internal events
  logic in_lookup, hit_evt, miss_evt, fill_evt, victim_dirty;
  assign in_lookup    = (state_q == ST_LOOKUP);
  assign hit_evt      = in_lookup && hit;
  assign miss_evt     = in_lookup && !hit;
  assign fill_evt     = (state_q == ST_AWAIT) && mem_rsp_valid;
  assign victim_dirty = (st_q[req_idx][vic_way] == LN_DIRTY);

  // control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      req_write_q <= 1'b0;
      req_addr_q  <= '0;
      req_wdata_q <= '0;
      vic_q       <= '0;
      rdata_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (cpu_valid) begin
            req_write_q <= cpu_write;
            req_addr_q  <= cpu_addr;
            req_wdata_q <= cpu_wdata;
            state_q     <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (hit) begin
            rdata_q <= req_write_q ? req_wdata_q : pick_byte(data_q[req_idx][hit_way], req_off);
            state_q <= ST_REPLY;
          end else begin
            vic_q   <= vic_way;
            state_q <= victim_dirty ? ST_EVICT : ST_FETCH;
          end
        end
        ST_EVICT: if (mem_req_ready) state_q <= ST_FETCH;
        ST_FETCH: if (mem_req_ready) state_q <= ST_AWAIT;
        ST_AWAIT: begin
          if (mem_rsp_valid) begin
            rdata_q <= req_write_q ? req_wdata_q : pick_byte(mem_rsp_rdata, req_off);
            state_q <= ST_REPLY;
          end
        end
        ST_REPLY: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  // line state, tag and age
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          st_q[s][w]  <= LN_INVALID;
          tag_q[s][w] <= '0;
          age_q[s][w] <= '0;
        end
      end
    end else begin
      if (in_lookup) begin
        for (int w = 0; w < WAYS; w++) age_q[req_idx][w] <= age_nx[w*AGE_BITS +: AGE_BITS];
      end
      if (hit_evt && req_write_q) st_q[req_idx][hit_way] <= LN_DIRTY;
      if (fill_evt) begin
        st_q[req_idx][vic_q]  <= req_write_q ? LN_DIRTY : LN_CLEAN;
        tag_q[req_idx][vic_q] <= req_tag;
        age_q[req_idx][vic_q] <= '0;
      end
    end
  end

  // line data
  always_ff @(posedge clk) begin
    if (hit_evt && req_write_q)
      data_q[req_idx][hit_way] <= merge_byte(data_q[req_idx][hit_way], req_off, req_wdata_q);
    if (fill_evt)
      data_q[req_idx][vic_q] <= req_write_q ? merge_byte(mem_rsp_rdata, req_off, req_wdata_q)
                                            : mem_rsp_rdata;
  end

  // ports
  assign cpu_ready     = (state_q == ST_REPLY);
  assign cpu_rdata     = rdata_q;
  assign mem_req_valid = (state_q == ST_EVICT) || (state_q == ST_FETCH);
  assign mem_req_write = (state_q == ST_EVICT);
  assign mem_req_addr  = (state_q == ST_EVICT) ? line_base(tag_q[req_idx][vic_q], req_idx)
                                               : line_base(req_tag, req_idx);
  assign mem_req_wdata = data_q[req_idx][vic_q];
  assign mem_rsp_ready = (state_q == ST_AWAIT);

  // assertions
  a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  a_r3_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    in_lookup |-> $onehot0(hit_vec));

  a_r4_free_way_used: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_evt && !(&set_valid)) |-> (st_q[req_idx][vic_way] == LN_INVALID));

  a_r5_hit_age_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> (age_q[req_idx][$past(hit_way)] == '0));

  a_r6_evict_only_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EVICT) |-> (st_q[req_idx][vic_q] == LN_DIRTY));

  a_r7_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[OFFSET_BITS-1:0] == '0));

  a_r8_fill_state: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt |=> (st_q[req_idx][vic_q] == (req_write_q ? LN_DIRTY : LN_CLEAN)));

  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

endmodule

// File: tb/tb_wbc_cache_ctrl.sv
`timescale 1ns/1ps
module tb_wbc_cache_ctrl;

  localparam int NSET = 4;
  localparam int NWAY = 8;
  localparam int AMAX = 15;
  localparam int MEMSZ = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0, cpu_write = 1'b0;
  logic [9:0]  cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_ready;
  logic [7:0]  cpu_rdata;
  logic        mem_req_valid, mem_req_write, mem_rsp_ready;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [9:0]  mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic [31:0] mem_rsp_rdata = '0;

  always #4 clk = ~clk;

  wbc_cache_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_rdata(mem_rsp_rdata)
  );

  int n_cmp = 0, n_bad = 0;
  logic [7:0] mem  [MEMSZ];
  logic [7:0] gold [MEMSZ];
  int m_st [NSET][NWAY];
  int m_tag[NSET][NWAY];
  int m_age[NSET][NWAY];
  logic        exp_wr_q[$];
  logic [9:0]  exp_ad_q[$];
  logic [31:0] exp_dt_q[$];
  bit waiting = 0;
  logic [31:0] lcg = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] gold_line(input logic [9:0] base);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = gold[base + b];
    return r;
  endfunction

  // reference model: decides hit, predicts memory traffic and the byte returned
  task automatic model(input bit wr, input logic [9:0] a, input logic [7:0] d,
                       output bit hit, output logic [7:0] er);
    int s, t, h, v, mx;
    s = int'(a[3:2]); t = int'(a[9:4]); h = -1;
    for (int w = 0; w < NWAY; w++) if (m_st[s][w] != 0 && m_tag[s][w] == t) h = w;
    for (int w = 0; w < NWAY; w++) if (m_age[s][w] < AMAX) m_age[s][w]++;
    if (h >= 0) begin
      m_age[s][h] = 0;
      if (wr) m_st[s][h] = 2;
      hit = 1;
    end else begin
      v = -1;
      for (int w = 0; w < NWAY; w++) if (m_st[s][w] == 0 && v < 0) v = w;
      if (v < 0) begin
        mx = -1;
        for (int w = 0; w < NWAY; w++) if (m_age[s][w] > mx) begin mx = m_age[s][w]; v = w; end
      end
      if (m_st[s][v] == 2) begin
        exp_wr_q.push_back(1'b1);
        exp_ad_q.push_back({m_tag[s][v][5:0], a[3:2], 2'b00});
        exp_dt_q.push_back(gold_line({m_tag[s][v][5:0], a[3:2], 2'b00}));
      end
      exp_wr_q.push_back(1'b0);
      exp_ad_q.push_back({a[9:2], 2'b00});
      exp_dt_q.push_back(32'h0);
      m_st[s][v] = wr ? 2 : 1; m_tag[s][v] = t; m_age[s][v] = 0;
      hit = 0;
    end
    if (wr) gold[a] = d;
    er = wr ? d : gold[a];
  endtask

  // memory responder and per-clock monitor
  initial begin
    bit req_fire = 0, req_wait = 0, rsp_fire = 0, rsp_pend = 0;
    int rsp_cnt = 0;
    logic [31:0] rsp_line = '0;
    logic [9:0]  p_addr = '0;
    logic        p_wr = 1'b0;
    forever begin
      @(negedge clk);
      if (req_fire) begin
        if (p_wr) begin
          for (int b = 0; b < 4; b++) mem[p_addr + b] = rsp_line[8*b +: 8];
        end else begin
          for (int b = 0; b < 4; b++) rsp_line[8*b +: 8] = mem[p_addr + b];
          rsp_pend = 1; rsp_cnt = int'(lcg[1:0]);
        end
      end
      if (rsp_fire) begin
        mem_rsp_valid = 1'b0;
        chk(cpu_ready == 1'b1, "R7", "ready after refill", 32'(cpu_ready), 1);
      end
      if (req_wait)
        chk(mem_req_valid && mem_req_addr == p_addr && mem_req_write == p_wr,
            "R9", "request held", {21'b0, mem_req_write, mem_req_addr}, {21'b0, p_wr, p_addr});
      if (cpu_ready && !waiting) chk(0, "R10", "unsolicited ready", 1, 0);
      if (!rst_n) chk(!mem_req_valid && !mem_rsp_ready && !cpu_ready, "R1", "outputs in reset",
                      {mem_req_valid, mem_rsp_ready, cpu_ready}, 0);
      lcg = lcg * 32'd1103515245 + 32'd12345;
      mem_req_ready = (lcg[5:4] != 2'b00);
      if (rsp_pend) begin
        if (rsp_cnt == 0) begin
          mem_rsp_valid = 1'b1; mem_rsp_rdata = rsp_line; rsp_pend = 0;
        end else rsp_cnt--;
      end
      req_fire = mem_req_valid && mem_req_ready;
      req_wait = mem_req_valid && !mem_req_ready;
      rsp_fire = mem_rsp_valid && mem_rsp_ready;
      p_addr = mem_req_addr; p_wr = mem_req_write;
      if (req_fire) begin
        if (mem_req_write) rsp_line = mem_req_wdata;
        if (exp_wr_q.size() == 0) begin
          chk(0, "R6", "unexpected memory request", {22'b0, mem_req_addr}, 0);
        end else begin
          chk(mem_req_write == exp_wr_q[0], exp_wr_q[0] ? "R6" : "R7", "request kind",
              32'(mem_req_write), 32'(exp_wr_q[0]));
          chk(mem_req_addr == exp_ad_q[0], exp_wr_q[0] ? "R6" : "R7", "request address",
              {22'b0, mem_req_addr}, {22'b0, exp_ad_q[0]});
          if (exp_wr_q[0]) chk(mem_req_wdata == exp_dt_q[0], "R6", "write-back line",
                               mem_req_wdata, exp_dt_q[0]);
          void'(exp_wr_q.pop_front()); void'(exp_ad_q.pop_front()); void'(exp_dt_q.pop_front());
        end
      end
    end
  end

  task automatic access(input bit wr, input logic [9:0] a, input logic [7:0] d, input string req);
    bit hit, done;
    logic [7:0] er;
    int n;
    model(wr, a, d, hit, er);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a; cpu_wdata = d; waiting = 1;
    n = 0; done = 0;
    while (!done && n < 2000) begin
      @(negedge clk); n++;
      if (cpu_ready) done = 1;
    end
    chk(done, req, "ready seen", 32'(done), 1);
    if (hit) chk(n == 2, hit && wr ? "R3" : "R2", "hit latency", n, 2);
    chk(cpu_rdata == er, req, "returned byte", {24'b0, cpu_rdata}, {24'b0, er});
    chk(exp_wr_q.size() == 0, req, "memory traffic complete", exp_wr_q.size(), 0);
    cpu_valid = 1'b0; waiting = 0;
  endtask

  function automatic logic [9:0] ad(input int t, input int s, input int o);
    return {6'(t), 2'(s), 2'(o)};
  endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    chk(0, "R10", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < MEMSZ; i++) begin
      mem[i] = 8'((i * 37 + 11) & 255);
      gold[i] = mem[i];
    end
    for (int s = 0; s < NSET; s++)
      for (int w = 0; w < NWAY; w++) begin m_st[s][w] = 0; m_tag[s][w] = 0; m_age[s][w] = 0; end
    repeat (3) @(negedge clk);
    chk(!cpu_ready && !mem_req_valid && !mem_rsp_ready, "R1", "reset outputs",
        {cpu_ready, mem_req_valid, mem_rsp_ready}, 0);
    rst_n = 1'b1;

    // first access misses (R1), refill (R7), read hit timing (R2)
    access(0, ad(1, 0, 1), 0, "R1");
    access(0, ad(1, 0, 3), 0, "R2");
    // write hit then readback (R3)
    access(1, ad(1, 0, 2), 8'hA5, "R3");
    access(0, ad(1, 0, 2), 0, "R3");
    // write miss allocates dirty (R8)
    access(1, ad(2, 0, 0), 8'h3C, "R8");
    access(0, ad(2, 0, 0), 0, "R8");
    // fill remaining free ways without write-back (R4)
    for (int t = 3; t <= 8; t++) access(0, ad(t, 0, t & 3), 0, "R4");
    // full set: oldest way holds dirty tag 1 -> write-back (R6)
    access(0, ad(9, 0, 1), 0, "R6");
    access(0, ad(1, 0, 2), 0, "R6");
    // clean victims in set 1 (R6 no write)
    for (int t = 20; t <= 29; t++) access(0, ad(t, 1, 0), 0, "R6");
    // saturation and tie-break in set 2 (R5)
    for (int t = 10; t <= 17; t++) access(0, ad(t, 2, 2), 0, "R5");
    for (int k = 0; k < 20; k++) access(k[0], ad(17, 2, k & 3), 8'(k), "R5");
    access(0, ad(18, 2, 0), 0, "R5");
    access(0, ad(11, 2, 0), 0, "R5");
    access(0, ad(10, 2, 0), 0, "R5");
    // random mix (R8, R9, R10)
    for (int k = 0; k < 400; k++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      access(lcg[20], ad(int'(lcg[27:24]) % 12, int'(lcg[11:10]), int'(lcg[3:2])),
             lcg[19:12], "R8");
    end
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule